// File: doc/BRIEF.md
# UART Receive Word Packer with Idle Flush

This block sits behind a UART deserializer. It collects received bytes into 32-bit words, four bytes to a word, with the earliest byte in bits 7:0. Each completed word enters a receive word FIFO, and software reads the FIFO through a small register port. Bytes that do not yet fill a word wait in a packing buffer. They reach the FIFO only when a stale event flushes them as a partial word, with the unused upper lanes zero.

A stale event has two causes. Software can request one with a command. It also happens when the line stays idle for a programmed number of character times while received data is still waiting. A stale event sets a sticky stale status bit and disarms the idle detector. The detector stays disarmed until software clears the status and then re-arms it. A snapshot register records how many bytes arrived in the segment that the stale event closed, so software knows how many bytes of the last word are valid.

A watermark status bit compares the FIFO level against a programmable level. A single interrupt line combines the watermark and stale status bits, each passed through its own mask bit.

Top module: `rxpk_top`

## Requirements
- R1: Bytes are packed first-arrived into bits 7:0, then 15:8, 23:16 and 31:24. The fourth byte pushes the word into the FIFO. A read of the data register (address 6) returns the oldest word and removes it.
- R2: While fewer than four bytes are waiting, the FIFO level does not change. Status bits 6:4 give the waiting byte count (0 to 3). Status bits 15:8 give the FIFO level, and status bit 3 shows that the FIFO is not empty.
- R3: Writing the command register (address 0) with bit 1 set forces a stale event at once. Any waiting bytes are pushed as one word with the unused upper lanes zero, and status bit 1 (stale) is set, even when nothing is waiting.
- R4: After a stale event the detector is disarmed (status bit 2 low). Command bit 3 (arm) is ignored while the stale status is set. Command bit 2 clears the stale status; arm takes effect when it is written together with or after the clear. While disarmed, no idle stale event occurs.
- R5: When the detector is armed and data is waiting, a stale event fires on the Nth char_tick after the last received byte. Each received byte restarts the count. N is formed from address 4: bits 4:0 are the low part and bits 15:8 the high part, so N = high*32 + low. A programmed zero acts as one.
- R6: Status bit 0 (watermark) is high when the watermark register (address 3) is non-zero and the FIFO level is at least its value.
- R7: irq is high exactly when a status source is set and enabled. Mask register (address 2) bit 0 enables the watermark source and bit 1 the stale source.
- R8: On a stale event, the snapshot register (address 5) takes the number of bytes received since the previous stale event or receiver reset.
- R9: Command bit 0 resets the receiver. It empties the FIFO and packing buffer, zeroes the snapshot and byte count, and clears both the stale status and the armed state.
- R10: A word completed while the FIFO is full is discarded. A data read of an empty FIFO returns zero and changes nothing.
- R11: After reset all status bits, the snapshot and irq are zero, and the timeout register reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte_vld | input | 1 | One received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| char_tick | input | 1 | One pulse per character time, the idle-timer unit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 6 pops the FIFO |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| irq | output | 1 | Masked OR of the watermark and stale status bits |

## Verification
The bench builds the block with an eight-word FIFO. This lets random byte streams overflow it within a few dozen bytes, so the discard rule and a full drain are reached quickly. The default 5+8-bit timeout split is kept. A low-field value of 3, a high-field value of 1 (giving 32 ticks) and a zero value each show the restart-on-byte behaviour and the split encoding in short tick bursts. Random phases interleave forced flushes, pops and status reads against a byte-level model of the packing buffer and the snapshot count.

// File: rtl/rxpk_pkg.sv
`timescale 1ns/1ps
package rxpk_pkg;
   typedef enum logic [2:0] {
      RA_CMD   = 3'd0,
      RA_STAT  = 3'd1,
      RA_MASK  = 3'd2,
      RA_WMARK = 3'd3,
      RA_TOUT  = 3'd4,
      RA_SNAP  = 3'd5,
      RA_DATA  = 3'd6
   } rxpk_addr_e;

   // command word, low nibble of a write to RA_CMD
   typedef struct packed {
      logic arm;        // bit 3
      logic clr_stale;  // bit 2
      logic frc_stale;  // bit 1
      logic rx_rst;     // bit 0
   } rxpk_cmd_t;

   localparam int TOUT_HI_POS = 8;
   localparam int STAT_CNT_POS = 4;
   localparam int STAT_LVL_POS = 8;
endpackage

// File: rtl/rxpk_lane_packer.sv
`timescale 1ns/1ps
module rxpk_lane_packer #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          byte_vld,
   input  logic [BYTE_W-1:0]             byte_dat,
   input  logic                          flush,
   output logic                          push,
   output logic [LANES*BYTE_W-1:0]       push_word,
   output logic [$clog2(LANES+1)-1:0]    pack_cnt
);
   localparam int WORD_W = LANES * BYTE_W;
   localparam int CNT_W  = $clog2(LANES + 1);

   logic [WORD_W-1:0] pk_q;
   logic [WORD_W-1:0] merged;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  merged_cnt;

   // incoming byte lands in the lane selected by the current fill count
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*BYTE_W +: BYTE_W] =
         (byte_vld && cnt_q == CNT_W'(l)) ? byte_dat : pk_q[l*BYTE_W +: BYTE_W];
   end

   assign merged_cnt = cnt_q + CNT_W'(byte_vld);
   assign push       = !clear &&
                       ((merged_cnt == CNT_W'(LANES)) || (flush && merged_cnt != '0));
   assign push_word  = merged;
   assign pack_cnt   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pk_q  <= '0;
         cnt_q <= '0;
      end else if (clear || push) begin
         pk_q  <= '0;
         cnt_q <= '0;
      end else begin
         pk_q  <= merged;
         cnt_q <= merged_cnt;
      end
   end
endmodule

// File: rtl/rxpk_word_fifo.sv
`timescale 1ns/1ps
module rxpk_word_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        push,
   input  logic [W-1:0]                din,
   input  logic                        pop,
   output logic [W-1:0]                dout,
   output logic [$clog2(DEPTH+1)-1:0]  level,
   output logic                        empty,
   output logic                        full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [LW-1:0] lvl_q;
   logic          do_push, do_pop;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (lvl_q == '0);
   assign full    = (lvl_q == LW'(DEPTH));
   assign do_push = push && !full && !clear;
   assign do_pop  = pop && !empty && !clear;
   assign dout    = mem[rd_ptr];
   assign level   = lvl_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (do_push && wr_ptr == PW'(e)) mem[e] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         lvl_q  <= '0;
      end else if (clear) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         lvl_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr);
         if (do_pop)  rd_ptr <= step(rd_ptr);
         lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
      end
   end
endmodule

// File: rtl/rxpk_idle_timer.sv
`timescale 1ns/1ps
module rxpk_idle_timer #(
   parameter int TW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          restart,
   input  logic          active,
   input  logic          tick,
   input  logic [TW-1:0] limit,
   output logic          fire
);
   logic [TW-1:0] cnt_q;
   logic [TW:0]   nxt;

   assign nxt  = {1'b0, cnt_q} + 1'b1;
   assign fire = active && tick && !restart && !clear && (nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cnt_q <= '0;
      else if (clear || restart || !active || fire) cnt_q <= '0;
      else if (tick)                               cnt_q <= nxt[TW-1:0];
   end
endmodule

// File: rtl/rxpk_top.sv
`timescale 1ns/1ps
module rxpk_top #(
   parameter int FIFO_DEPTH = 16,
   parameter int TO_LO_W    = 5,
   parameter int TO_HI_W    = 8,
   parameter int SNAP_W     = 16,
   parameter int WM_W       = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_byte_vld,
   input  logic [7:0]  rx_byte,
   input  logic        char_tick,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq
);
   import rxpk_pkg::*;

   localparam int LANES  = 4;
   localparam int BYTE_W = 8;
   localparam int WORD_W = LANES * BYTE_W;
   localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
   localparam int CNT_W  = $clog2(LANES + 1);
   localparam int TO_W   = TO_LO_W + TO_HI_W;

   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 255) begin : g_bad_depth
      $error("rxpk_top: FIFO_DEPTH must lie in 2..255");
   end
   if (TO_LO_W < 1 || TO_LO_W > 8) begin : g_bad_lo
      $error("rxpk_top: TO_LO_W must lie in 1..8");
   end
   if (TO_HI_W < 1 || TO_HI_W > 16) begin : g_bad_hi
      $error("rxpk_top: TO_HI_W must lie in 1..16");
   end
   if (SNAP_W < 1 || SNAP_W > 32 || WM_W < 1 || WM_W > 16) begin : g_bad_w
      $error("rxpk_top: SNAP_W must lie in 1..32 and WM_W in 1..16");
   end

   // ---------------- register decode
   rxpk_cmd_t cmd;
   logic      cmd_wr, do_rxrst, do_frc, do_clr, do_arm;
   assign cmd      = rxpk_cmd_t'(reg_wdata[3:0]);
   assign cmd_wr   = reg_wr && (reg_addr == RA_CMD);
   assign do_rxrst = cmd_wr && cmd.rx_rst;
   assign do_frc   = cmd_wr && cmd.frc_stale && !do_rxrst;
   assign do_clr   = cmd_wr && cmd.clr_stale;
   assign do_arm   = cmd_wr && cmd.arm;

   logic [1:0]         mask_q;
   logic [WM_W-1:0]    wmark_q;
   logic [TO_LO_W-1:0] tlo_q;
   logic [TO_HI_W-1:0] thi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         wmark_q <= '0;
         tlo_q   <= TO_LO_W'(1);
         thi_q   <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_MASK:  mask_q  <= reg_wdata[1:0];
            RA_WMARK: wmark_q <= reg_wdata[WM_W-1:0];
            RA_TOUT: begin
               tlo_q <= reg_wdata[TO_LO_W-1:0];
               thi_q <= reg_wdata[TOUT_HI_POS +: TO_HI_W];
            end
            default: ;
         endcase
      end
   end

   logic [TO_W-1:0] tout_raw, tout_lim;
   assign tout_raw = {thi_q, tlo_q};
   assign tout_lim = (tout_raw == '0) ? TO_W'(1) : tout_raw;

   // ---------------- datapath
   logic              stale_evt, timer_fire;
   logic              pk_push;
   logic [WORD_W-1:0] pk_word;
   logic [CNT_W-1:0]  pack_cnt;
   logic              fifo_pop, fifo_empty, fifo_full;
   logic [WORD_W-1:0] fifo_dout;
   logic [LVL_W-1:0]  fifo_level;

   assign stale_evt = !do_rxrst && (do_frc || timer_fire);
   assign fifo_pop  = reg_rd && (reg_addr == RA_DATA) && !fifo_empty;

   rxpk_lane_packer #(.LANES(LANES), .BYTE_W(BYTE_W)) i_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (do_rxrst),
      .byte_vld  (rx_byte_vld),
      .byte_dat  (rx_byte),
      .flush     (stale_evt),
      .push      (pk_push),
      .push_word (pk_word),
      .pack_cnt  (pack_cnt)
   );

   rxpk_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (do_rxrst),
      .push  (pk_push),
      .din   (pk_word),
      .pop   (fifo_pop),
      .dout  (fifo_dout),
      .level (fifo_level),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   // ---------------- stale control
   logic stale_st, armed;
   logic pending;
   assign pending = (pack_cnt != '0) || !fifo_empty;

   rxpk_idle_timer #(.TW(TO_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (do_rxrst),
      .restart (rx_byte_vld),
      .active  (armed && pending),
      .tick    (char_tick),
      .limit   (tout_lim),
      .fire    (timer_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stale_st <= 1'b0;
         armed    <= 1'b0;
      end else if (do_rxrst) begin
         stale_st <= 1'b0;
         armed    <= 1'b0;
      end else if (stale_evt) begin
         stale_st <= 1'b1;
         armed    <= 1'b0;
      end else begin
         if (do_clr) stale_st <= 1'b0;
         if (do_arm && (!stale_st || do_clr)) armed <= 1'b1;
      end
   end

   logic [SNAP_W-1:0] run_q, snap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         snap_q <= '0;
      end else if (do_rxrst) begin
         run_q  <= '0;
         snap_q <= '0;
      end else if (stale_evt) begin
         snap_q <= run_q + SNAP_W'(rx_byte_vld);
         run_q  <= '0;
      end else if (rx_byte_vld) begin
         run_q  <= run_q + 1'b1;
      end
   end

   // ---------------- status, interrupt, read mux
   logic wm_st;
   assign wm_st = (wmark_q != '0) && (32'(fifo_level) >= 32'(wmark_q));
   assign irq   = (mask_q[0] && wm_st) || (mask_q[1] && stale_st);

   logic [31:0] stat_word;
   assign stat_word = 32'(wm_st)
                    | (32'(stale_st)    << 1)
                    | (32'(armed)       << 2)
                    | (32'(!fifo_empty) << 3)
                    | (32'(pack_cnt)    << STAT_CNT_POS)
                    | (32'(fifo_level)  << STAT_LVL_POS);

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         case (reg_addr)
            RA_STAT:  reg_rdata = stat_word;
            RA_MASK:  reg_rdata = 32'(mask_q);
            RA_WMARK: reg_rdata = 32'(wmark_q);
            RA_TOUT:  reg_rdata = 32'(tlo_q) | (32'(thi_q) << TOUT_HI_POS);
            RA_SNAP:  reg_rdata = 32'(snap_q);
            RA_DATA:  reg_rdata = fifo_empty ? '0 : fifo_dout;
            default:  reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rxpk_checker.sv
`timescale 1ns/1ps
module rxpk_checker #(
   parameter int FIFO_DEPTH = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cmd_wr,
   input logic [3:0]                    cmd_bits,
   input logic                          stale_st,
   input logic                          armed,
   input logic [2:0]                    pack_cnt,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] level,
   input logic [31:0]                   wmark,
   input logic                          mask_wm,
   input logic                          irq
);
   a_r3_force_raises_stale: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_bits[1] && !cmd_bits[0]) |=> stale_st);

   a_r4_stale_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stale_st && !(cmd_wr && (cmd_bits[2] || cmd_bits[0]))) |=> stale_st);

   a_r4_disarm_on_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stale_st) |-> !armed);

   a_r4_arm_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (stale_st && !armed && !(cmd_wr && (cmd_bits[2] || cmd_bits[0]))) |=> !armed);

   a_r2_pack_range: assert property (@(posedge clk) disable iff (!rst_n)
      pack_cnt <= 3'd3);

   a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(level) <= FIFO_DEPTH);

   a_r9_rxrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_bits[0]) |=> (level == '0 && pack_cnt == 3'd0 && !stale_st && !armed));

   a_r6_wmark_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wm && wmark != 32'd0 && 32'(level) >= wmark) |-> irq);
endmodule

bind rxpk_top rxpk_checker #(.FIFO_DEPTH(FIFO_DEPTH)) i_rxpk_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_wr   (cmd_wr),
   .cmd_bits (reg_wdata[3:0]),
   .stale_st (stale_st),
   .armed    (armed),
   .pack_cnt (3'(pack_cnt)),
   .level    (fifo_level),
   .wmark    (32'(wmark_q)),
   .mask_wm  (mask_q[0]),
   .irq      (irq)
);

// File: tb/test_rxpk_top.sv
`timescale 1ns/1ps
module test_rxpk_top;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rx_byte_vld, char_tick, reg_wr, reg_rd;
   logic [7:0]  rx_byte;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   rxpk_top #(.FIFO_DEPTH(DEPTH), .TO_LO_W(5), .TO_HI_W(8)) i_rxpk_top (
      .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
      .char_tick(char_tick), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // byte-level model
   logic [7:0]  m_pend[$];
   logic [31:0] m_words[$];
   int          m_run  = 0;
   int          m_snap = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_bytes(input logic [7:0] q[$]);
      logic [31:0] w = '0;
      foreach (q[i]) w[8*i +: 8] = q[i];
      return w;
   endfunction

   task automatic m_push(input logic [31:0] w);
      if (m_words.size() < DEPTH) m_words.push_back(w);
   endtask

   task automatic m_byte(input logic [7:0] b);
      m_pend.push_back(b);
      m_run++;
      if (m_pend.size() == 4) begin
         m_push(pack_bytes(m_pend));
         m_pend.delete();
      end
   endtask

   task automatic m_stale();
      if (m_pend.size() > 0) m_push(pack_bytes(m_pend));
      m_pend.delete();
      m_snap = m_run;
      m_run  = 0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_byte_vld = 1'b1;
      rx_byte     = b;
      @(negedge clk);
      rx_byte_vld = 1'b0;
      m_byte(b);
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         char_tick = 1'b1;
         @(negedge clk);
         char_tick = 1'b0;
      end
   endtask

   task automatic read_data_chk(input string req);
      logic [31:0] d, e;
      reg_read(3'd6, d);
      e = (m_words.size() > 0) ? m_words.pop_front() : 32'h0;
      check(req, d, e);
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd7171));
      rst_n = 1'b0; rx_byte_vld = 0; rx_byte = 0; char_tick = 0;
      reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      reg_read(3'd1, d); check("R11 status", d, 32'h0);
      check("R11 irq", 32'(irq), 32'h0);
      reg_read(3'd5, d); check("R11 snapshot", d, 32'h0);
      reg_read(3'd4, d); check("R11 timeout", d, 32'h1);
      reg_write(3'd2, 32'h3);

      // R2 partial bytes stay in the packing buffer
      send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
      reg_read(3'd1, d); check("R2 count 3 level 0", d, 32'h30);
      read_data_chk("R10 empty read");
      // R1 fourth byte completes the word
      send_byte(8'h44);
      reg_read(3'd1, d); check("R1 level 1", d, 32'h108);
      read_data_chk("R1 packed order");

      // R3 forced flush, R8 snapshot
      send_byte(8'h55); send_byte(8'h66);
      reg_write(3'd0, 32'h2); m_stale();
      reg_read(3'd1, d); check("R3 stale status", d, 32'h10A);
      check("R7 stale irq", 32'(irq), 32'h1);
      reg_read(3'd5, d); check("R8 snapshot", d, 32'(m_snap));
      read_data_chk("R3 partial word");

      // R4 re-arm rules
      reg_write(3'd0, 32'h8);
      reg_read(3'd1, d); check("R4 arm ignored while pending", d, 32'h2);
      reg_write(3'd0, 32'h4);
      send_byte(8'h77);
      pulse_ticks(40);
      reg_read(3'd1, d); check("R4 no event when disarmed", d, 32'h10);
      check("R7 irq low", 32'(irq), 32'h0);
      reg_write(3'd0, 32'hC);
      reg_read(3'd1, d); check("R4 armed after clear", d, 32'h14);

      // R5 idle timeout with restart
      reg_write(3'd4, 32'd3);
      pulse_ticks(2);
      send_byte(8'h88);
      pulse_ticks(2);
      reg_read(3'd1, d); check("R5 restart on byte", d, 32'h24);
      pulse_ticks(1); m_stale();
      reg_read(3'd1, d); check("R5 timeout fired", d, 32'h10A);
      read_data_chk("R5 flushed word");
      reg_read(3'd5, d); check("R8 snapshot after timeout", d, 32'(m_snap));
      // R5 high field: 1<<8 gives 32 ticks
      reg_write(3'd4, 32'h100);
      reg_write(3'd0, 32'hC);
      send_byte(8'h99);
      pulse_ticks(31);
      reg_read(3'd1, d); check("R5 high field not yet", d, 32'h14);
      pulse_ticks(1); m_stale();
      reg_read(3'd1, d); check("R5 high field fired", d, 32'h10A);
      read_data_chk("R5 high field word");
      // R5 zero acts as one
      reg_write(3'd4, 32'h0);
      reg_write(3'd0, 32'hC);
      send_byte(8'hAA);
      pulse_ticks(1); m_stale();
      reg_read(3'd1, d); check("R5 zero acts as one", d, 32'h10A);
      read_data_chk("R5 zero word");

      // R6 / R7 watermark
      reg_write(3'd0, 32'h4);
      reg_write(3'd2, 32'h1);
      reg_write(3'd3, 32'd2);
      for (int i = 0; i < 4; i++) send_byte(8'(8'hB0 + i));
      check("R6 below level", 32'(irq), 32'h0);
      for (int i = 0; i < 4; i++) send_byte(8'(8'hC0 + i));
      reg_read(3'd1, d); check("R6 watermark status", d, 32'h209);
      check("R6 watermark irq", 32'(irq), 32'h1);
      reg_write(3'd2, 32'h0);
      check("R7 masked irq", 32'(irq), 32'h0);
      reg_write(3'd2, 32'h3);

      // R10 overflow drop and drain
      for (int i = 0; i < 32; i++) send_byte(8'(i * 7 + 3));
      reg_read(3'd1, d); check("R10 full level", d & 32'hFF70, 32'h800);
      for (int i = 0; i < DEPTH; i++) read_data_chk("R10 drain order");
      read_data_chk("R10 read empty");

      // R9 receiver reset
      send_byte(8'hD1); send_byte(8'hD2);
      reg_write(3'd0, 32'h2); m_stale();
      send_byte(8'hD3);
      reg_write(3'd0, 32'h1);
      m_pend.delete(); m_words.delete(); m_run = 0; m_snap = 0;
      reg_read(3'd1, d); check("R9 status cleared", d, 32'h0);
      reg_read(3'd5, d); check("R9 snapshot cleared", d, 32'h0);
      read_data_chk("R9 fifo cleared");

      // random mix
      for (int it = 0; it < 700; it++) begin
         int r = $urandom_range(0, 9);
         if (r <= 5) begin
            send_byte(8'($urandom));
         end else if (r == 6) begin
            reg_write(3'd0, 32'h2); m_stale();
            reg_read(3'd5, d); check("R8 random snapshot", d, 32'(m_snap));
         end else if (r <= 8) begin
            read_data_chk("R1 random word");
         end else begin
            reg_read(3'd1, d);
            check("R2 random count/level", d & 32'hFF70,
                  (32'(m_pend.size()) << 4) | (32'(m_words.size()) << 8));
         end
      end

      finish_run();
   end
endmodule